// File: doc/BRIEF.md
# Tag-Matching Instruction Window

This block is a small out-of-order issue window. Instructions arrive already renamed. Each one carries an opcode, a destination physical tag and two source operands. A source that is known on arrival brings its value. A source that is still being computed brings only the physical tag of the result it waits for. An instruction is accepted whether or not its destination register is still being produced by an older instruction.

A single result bus broadcasts a tag and a value each cycle. Every waiting source field in the window compares itself against that tag. On a match it keeps the value and becomes ready. A slot whose two sources are both ready competes for the single issue port, and the lowest-numbered competitor wins. The winning slot leaves the window and its contents appear on registered issue outputs. Those outputs include the slot number the destination tag belonged to. A younger instruction whose inputs are ready can therefore pass an older one that is still waiting.

Top module: `tag_issue_window`

## Requirements
- R1: After a synchronous active-high reset, no slot holds an instruction, `ins_ready` is 1 and `iss_valid` is 0.
- R2: `ins_ready` is 0 exactly when all SLOTS slots hold instructions. An instruction offered while `ins_ready` is 0 is dropped and never issues. An accepted instruction goes into the lowest-numbered empty slot.
- R3: A source marked ready on entry (`ins_sX_rdy`=1) stores `ins_sX_val` and is issued with that value unchanged.
- R4: A waiting source takes `bc_val` at the clock edge where `bc_valid` is 1 and `bc_tag` equals its tag. A broadcast carrying any other tag leaves it waiting.
- R5: If a source enters waiting and a broadcast with its tag arrives at the same edge, the source is stored as ready with `bc_val`.
- R6: A slot may issue when it holds an instruction and both of its sources are ready. Among those slots the lowest-numbered one is chosen. One clock edge after it is chosen, `iss_valid` is 1 for one cycle with that slot's `iss_op`, `iss_dst`, `iss_slot`, `iss_a` (source 1) and `iss_b` (source 2).
- R7: The chosen slot is emptied at the same edge that presents it on the issue outputs. It can be filled again from the following cycle.
- R8: A later instruction with ready sources issues ahead of an earlier one that is still waiting.
- R9: One broadcast completes every matching waiting field in the window at once: both sources of a slot, and fields in several slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Offer an instruction this cycle |
| ins_ready | output | 1 | At least one slot is empty |
| ins_op | input | OP_W | Opcode |
| ins_dst | input | TAG_W | Destination physical tag |
| ins_s1_rdy | input | 1 | Source 1 value is known |
| ins_s1_tag | input | TAG_W | Source 1 producer tag |
| ins_s1_val | input | DATA_W | Source 1 value |
| ins_s2_rdy | input | 1 | Source 2 value is known |
| ins_s2_tag | input | TAG_W | Source 2 producer tag |
| ins_s2_val | input | DATA_W | Source 2 value |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| iss_valid | output | 1 | Issue outputs carry an instruction |
| iss_op | output | OP_W | Issued opcode |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_slot | output | $clog2(SLOTS) | Slot the instruction left |
| iss_a | output | DATA_W | Source 1 value |
| iss_b | output | DATA_W | Source 2 value |

## Verification
Two events can land on the same edge: a new instruction being written, and a result broadcast that wakes one of its sources. The bench drives both at once on an entry whose source waits for the broadcast tag. It expects the instruction to issue on the next edge carrying the broadcast value. A design that misses the wake-up would hold the instruction forever. A second collision is a slot being freed by issue while an earlier-waiting slot wakes. The bench judges this from the order and slot numbers of the issue pulses across sweeps of broadcast order.

// File: rtl/tiw_pkg.sv
package tiw_pkg;
  localparam int DEF_SLOTS  = 4;
  localparam int DEF_OP_W   = 4;
  localparam int DEF_TAG_W  = 4;
  localparam int DEF_DATA_W = 16;

  typedef enum logic {
    OPND_WAIT = 1'b0,
    OPND_HAVE = 1'b1
  } opnd_state_e;
endpackage

// File: rtl/tiw_pick.sv
module tiw_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/tiw_operand.sv
module tiw_operand
  import tiw_pkg::*;
#(
  parameter int TAG_W  = DEF_TAG_W,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              live,
  input  logic              ld_rdy,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              rdy,
  output logic [DATA_W-1:0] val
);
  // A waiting field keeps its tag in the low bits of the value register.
  opnd_state_e       st;
  logic [DATA_W-1:0] fld;
  logic              ld_hit;
  logic              wait_hit;

  assign ld_hit   = bc_valid && (bc_tag == ld_tag);
  assign wait_hit = live && (st == OPND_WAIT) && bc_valid &&
                    (bc_tag == fld[TAG_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= OPND_WAIT;
    end else if (load) begin
      st <= (ld_rdy || ld_hit) ? OPND_HAVE : OPND_WAIT;
    end else if (wait_hit) begin
      st <= OPND_HAVE;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      if (ld_rdy)      fld <= ld_val;
      else if (ld_hit) fld <= bc_val;
      else             fld <= DATA_W'(ld_tag);
    end else if (wait_hit) begin
      fld <= bc_val;
    end
  end

  assign rdy = (st == OPND_HAVE);
  assign val = fld;
endmodule

// File: rtl/tiw_slot.sv
module tiw_slot
  import tiw_pkg::*;
#(
  parameter int OP_W   = DEF_OP_W,
  parameter int TAG_W  = DEF_TAG_W,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              drop,
  input  logic [OP_W-1:0]   ld_op,
  input  logic [TAG_W-1:0]  ld_dst,
  input  logic              ld_r1,
  input  logic [TAG_W-1:0]  ld_t1,
  input  logic [DATA_W-1:0] ld_v1,
  input  logic              ld_r2,
  input  logic [TAG_W-1:0]  ld_t2,
  input  logic [DATA_W-1:0] ld_v2,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              vld,
  output logic              both_rdy,
  output logic [OP_W-1:0]   op,
  output logic [TAG_W-1:0]  dst,
  output logic [DATA_W-1:0] v1,
  output logic [DATA_W-1:0] v2
);
  logic r1, r2;

  always_ff @(posedge clk) begin
    if (rst)       vld <= 1'b0;
    else if (load) vld <= 1'b1;
    else if (drop) vld <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      op  <= ld_op;
      dst <= ld_dst;
    end
  end

  tiw_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src1 (
    .clk(clk), .rst(rst), .load(load), .live(vld),
    .ld_rdy(ld_r1), .ld_tag(ld_t1), .ld_val(ld_v1),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .rdy(r1), .val(v1)
  );

  tiw_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src2 (
    .clk(clk), .rst(rst), .load(load), .live(vld),
    .ld_rdy(ld_r2), .ld_tag(ld_t2), .ld_val(ld_v2),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .rdy(r2), .val(v2)
  );

  assign both_rdy = r1 && r2;
endmodule

// File: rtl/tag_issue_window.sv
module tag_issue_window
  import tiw_pkg::*;
#(
  parameter int SLOTS  = DEF_SLOTS,
  parameter int OP_W   = DEF_OP_W,
  parameter int TAG_W  = DEF_TAG_W,
  parameter int DATA_W = DEF_DATA_W,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [OP_W-1:0]   ins_op,
  input  logic [TAG_W-1:0]  ins_dst,
  input  logic              ins_s1_rdy,
  input  logic [TAG_W-1:0]  ins_s1_tag,
  input  logic [DATA_W-1:0] ins_s1_val,
  input  logic              ins_s2_rdy,
  input  logic [TAG_W-1:0]  ins_s2_tag,
  input  logic [DATA_W-1:0] ins_s2_val,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              iss_valid,
  output logic [OP_W-1:0]   iss_op,
  output logic [TAG_W-1:0]  iss_dst,
  output logic [SLOT_W-1:0] iss_slot,
  output logic [DATA_W-1:0] iss_a,
  output logic [DATA_W-1:0] iss_b
);
  logic [SLOTS-1:0]  slot_vld;
  logic [SLOTS-1:0]  slot_rdy;
  logic [SLOTS-1:0]  free_oh;
  logic [SLOTS-1:0]  sel_oh;
  logic [SLOTS-1:0]  load_vec;
  logic              free_any;
  logic              sel_any;
  logic [SLOT_W-1:0] sel_idx;

  logic [OP_W-1:0]   s_op  [SLOTS];
  logic [TAG_W-1:0]  s_dst [SLOTS];
  logic [DATA_W-1:0] s_v1  [SLOTS];
  logic [DATA_W-1:0] s_v2  [SLOTS];

  tiw_pick #(.N(SLOTS)) u_free_pick (
    .req(~slot_vld), .gnt(free_oh), .any(free_any)
  );

  tiw_pick #(.N(SLOTS)) u_iss_pick (
    .req(slot_vld & slot_rdy), .gnt(sel_oh), .any(sel_any)
  );

  assign ins_ready = free_any;
  assign load_vec  = (ins_valid && free_any) ? free_oh : '0;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    tiw_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst(rst),
      .load(load_vec[g]), .drop(sel_oh[g]),
      .ld_op(ins_op), .ld_dst(ins_dst),
      .ld_r1(ins_s1_rdy), .ld_t1(ins_s1_tag), .ld_v1(ins_s1_val),
      .ld_r2(ins_s2_rdy), .ld_t2(ins_s2_tag), .ld_v2(ins_s2_val),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .vld(slot_vld[g]), .both_rdy(slot_rdy[g]),
      .op(s_op[g]), .dst(s_dst[g]), .v1(s_v1[g]), .v2(s_v2[g])
    );
  end

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (sel_oh[i]) sel_idx = SLOT_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) iss_valid <= 1'b0;
    else     iss_valid <= sel_any;
  end

  always_ff @(posedge clk) begin
    if (sel_any) begin
      iss_op   <= s_op[sel_idx];
      iss_dst  <= s_dst[sel_idx];
      iss_slot <= sel_idx;
      iss_a    <= s_v1[sel_idx];
      iss_b    <= s_v2[sel_idx];
    end
  end
endmodule

// File: rtl/tiw_chk.sv
module tiw_chk #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [SLOTS-1:0]  slot_vld,
  input logic [SLOTS-1:0]  sel_oh,
  input logic              sel_any,
  input logic              iss_valid,
  input logic [SLOT_W-1:0] iss_slot
);
  // R6
  pick_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_oh));

  // R6
  issue_follows_chk: assert property (@(posedge clk) disable iff (rst)
    sel_any |=> iss_valid);

  // R7
  freed_on_issue_chk: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !slot_vld[iss_slot]);

  // R2
  fill_count_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_ready && !sel_any) |=>
      ($countones(slot_vld) == $past($countones(slot_vld)) + 1));

  // R7
  drain_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!(ins_valid && ins_ready) && sel_any) |=>
      ($countones(slot_vld) + 1 == $past($countones(slot_vld))));

  // R2
  refuse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ins_ready && !sel_any) |=> $stable(slot_vld));
endmodule

bind tag_issue_window tiw_chk #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .slot_vld(slot_vld), .sel_oh(sel_oh), .sel_any(sel_any),
  .iss_valid(iss_valid), .iss_slot(iss_slot)
);

// File: tb/sim_tag_issue_window.sv
module sim_tag_issue_window;
  localparam int SLOTS = 4, OP_W = 4, TAG_W = 4, DATA_W = 16, SLOT_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_valid = 1'b0, ins_ready;
  logic [OP_W-1:0] ins_op = '0;
  logic [TAG_W-1:0] ins_dst = '0, ins_s1_tag = '0, ins_s2_tag = '0;
  logic ins_s1_rdy = 1'b0, ins_s2_rdy = 1'b0;
  logic [DATA_W-1:0] ins_s1_val = '0, ins_s2_val = '0;
  logic bc_valid = 1'b0;
  logic [TAG_W-1:0] bc_tag = '0;
  logic [DATA_W-1:0] bc_val = '0;
  logic iss_valid;
  logic [OP_W-1:0] iss_op;
  logic [TAG_W-1:0] iss_dst;
  logic [SLOT_W-1:0] iss_slot;
  logic [DATA_W-1:0] iss_a, iss_b;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tag_issue_window #(.SLOTS(SLOTS), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_op(ins_op), .ins_dst(ins_dst),
    .ins_s1_rdy(ins_s1_rdy), .ins_s1_tag(ins_s1_tag), .ins_s1_val(ins_s1_val),
    .ins_s2_rdy(ins_s2_rdy), .ins_s2_tag(ins_s2_tag), .ins_s2_val(ins_s2_val),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_slot(iss_slot), .iss_a(iss_a), .iss_b(iss_b)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic put(input logic [3:0] op, input logic [3:0] dst,
                     input bit r1, input logic [3:0] t1, input logic [15:0] v1,
                     input bit r2, input logic [3:0] t2, input logic [15:0] v2);
    ins_valid = 1'b1; ins_op = op; ins_dst = dst;
    ins_s1_rdy = r1; ins_s1_tag = t1; ins_s1_val = v1;
    ins_s2_rdy = r2; ins_s2_tag = t2; ins_s2_val = v2;
    step();
    ins_valid = 1'b0;
  endtask

  task automatic bcast(input logic [3:0] tag, input logic [15:0] val);
    bc_valid = 1'b1; bc_tag = tag; bc_val = val;
    step();
    bc_valid = 1'b0;
  endtask

  task automatic chk_iss(input string req, input int slot, input logic [3:0] op,
                         input logic [3:0] dst, input logic [15:0] a, input logic [15:0] b);
    chk_eq(req, "iss_valid", 32'(iss_valid), 32'd1);
    chk_eq(req, "iss_slot", 32'(iss_slot), 32'(slot));
    chk_eq(req, "iss_op", 32'(iss_op), 32'(op));
    chk_eq(req, "iss_dst", 32'(iss_dst), 32'(dst));
    chk_eq(req, "iss_a", 32'(iss_a), 32'(a));
    chk_eq(req, "iss_b", 32'(iss_b), 32'(b));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk_eq("R1", "ins_ready", 32'(ins_ready), 32'd1);
    chk_eq("R1", "iss_valid", 32'(iss_valid), 32'd0);

    // R3 ready operands pass through unchanged
    put(4'h3, 4'h5, 1, 4'h0, 16'h1111, 1, 4'h0, 16'h2222);
    step();
    chk_iss("R3", 0, 4'h3, 4'h5, 16'h1111, 16'h2222);
    step();
    chk_eq("R6", "single pulse", 32'(iss_valid), 32'd0);

    // R2 fill all slots with waiting instructions (tags 8..11)
    for (int i = 0; i < SLOTS; i++)
      put(4'(i), 4'(i + 4), 0, 4'(8 + i), 16'h0, 1, 4'h0, 16'(16'h100 + i));
    chk_eq("R2", "ins_ready full", 32'(ins_ready), 32'd0);
    put(4'hF, 4'hF, 1, 4'h0, 16'hDEAD, 1, 4'h0, 16'hBEEF); // refused
    step();
    chk_eq("R2", "refused no issue", 32'(iss_valid), 32'd0);
    bcast(4'h3, 16'h3333);
    step();
    chk_eq("R4", "no match stays", 32'(iss_valid), 32'd0);
    bcast(4'd10, 16'hAAAA);
    step();
    chk_iss("R4", 2, 4'd2, 4'd6, 16'hAAAA, 16'h0102);
    chk_eq("R7", "ins_ready after free", 32'(ins_ready), 32'd1);
    put(4'h9, 4'h1, 1, 4'h0, 16'h0001, 1, 4'h0, 16'h0002);
    step();
    chk_iss("R7", 2, 4'h9, 4'h1, 16'h0001, 16'h0002);
    bcast(4'd11, 16'hBBBB);
    bcast(4'd8, 16'h8888);
    chk_iss("R4", 3, 4'd3, 4'd7, 16'hBBBB, 16'h0103);
    step();
    chk_iss("R4", 0, 4'd0, 4'd4, 16'h8888, 16'h0100);
    bcast(4'd9, 16'h9999);
    step();
    chk_iss("R4", 1, 4'd1, 4'd5, 16'h9999, 16'h0101);
    step();
    chk_eq("R2", "refused never issues", 32'(iss_valid), 32'd0);
    chk_eq("R2", "empty ready", 32'(ins_ready), 32'd1);

    // R9 one broadcast wakes both fields of two slots
    put(4'h1, 4'h2, 0, 4'h6, 16'h0, 0, 4'h6, 16'h0);
    put(4'h2, 4'h3, 0, 4'h6, 16'h0, 0, 4'h6, 16'h0);
    bcast(4'h6, 16'h5A5A);
    step();
    chk_iss("R9", 0, 4'h1, 4'h2, 16'h5A5A, 16'h5A5A);
    step();
    chk_iss("R9", 1, 4'h2, 4'h3, 16'h5A5A, 16'h5A5A);
    step();

    // R5 broadcast on the insertion edge
    bc_valid = 1'b1; bc_tag = 4'h7; bc_val = 16'h7777;
    put(4'h4, 4'h8, 0, 4'h7, 16'h0, 1, 4'h0, 16'h0022);
    bc_valid = 1'b0;
    step();
    chk_iss("R5", 0, 4'h4, 4'h8, 16'h7777, 16'h0022);
    step();

    // R8 younger ready instruction passes an older waiting one
    put(4'h5, 4'h9, 0, 4'hC, 16'h0, 1, 4'h0, 16'h0055);
    put(4'h6, 4'hA, 1, 4'h0, 16'h0066, 1, 4'h0, 16'h0067);
    step();
    chk_iss("R8", 1, 4'h6, 4'hA, 16'h0066, 16'h0067);
    bcast(4'hC, 16'hC0C0);
    step();
    chk_iss("R8", 0, 4'h5, 4'h9, 16'hC0C0, 16'h0055);
    step();

    // R4 R6 sweep: rotate tag assignment, wake in tag order
    for (int rot = 0; rot < 4; rot++) begin
      for (int i = 0; i < SLOTS; i++)
        put(4'(i), 4'(i), 0, 4'(8 + ((rot + i) % 4)), 16'h0, 1, 4'h0, 16'(i));
      for (int k = 0; k < 4; k++) begin
        int s;
        s = (k - rot + 4) % 4;
        bcast(4'(8 + k), 16'(k * 16'h0101 + rot));
        step();
        chk_eq("R4", "sweep valid", 32'(iss_valid), 32'd1);
        chk_eq("R6", "sweep slot", 32'(iss_slot), 32'(s));
        chk_eq("R4", "sweep a", 32'(iss_a), 32'(k * 16'h0101 + rot));
      end
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule